// File: doc/BRIEF.md
# Dual-Period Edge-Serviced Watchdog

This block supervises a processor through a single service line, `kick_in`. Software keeps the supervisor quiet by toggling that line: either a rising or a falling transition is a valid service. A line that sits at one level, high or low, for too long is treated as a hung processor. When that happens the registered, active-low output `wd_fault_n` is driven low.

Two timeout lengths are used. After every reset event the block enters `ST_LONG`, a generous boot window of `LONG_CYC` clock cycles. It leaves that window early on the first service edge. Otherwise it leaves when the window runs out. Either way it moves to `ST_SHORT`, where each service edge must arrive within `SHORT_CYC` cycles. A missed deadline moves it to `ST_FAULT`, and it stays there until the next service edge, which returns it to `ST_SHORT`, or until a reset event. `wd_fault_n` may be looped back into the system reset. The reset event then clears the fault at once, and counting restarts in `ST_LONG` when the reset is released.

The transitions are named as follows:
- `T_BOOT_KICK` (LONG→SHORT on an edge)
- `T_BOOT_EXPIRE` (LONG→SHORT on expiry)
- `T_SERVICE` (SHORT→SHORT on an edge, with a reload)
- `T_MISS` (SHORT→FAULT)
- `T_RECOVER` (FAULT→SHORT on an edge)
- `T_RESET` (any state→LONG)

Top module: `wdog_dual_period`

## Requirements
- R1: A rising or a falling edge on `kick_in` is a service. It reloads the counter with `SHORT_CYC`, selects short mode and sets `wd_fault_n` to 1.
- R2: While `sys_rst` is 1, `wd_fault_n` is 1 and `long_mode` is 1 at once. The counter holds `LONG_CYC`.
- R3: Long mode ends either on the first serviced edge or after exactly `LONG_CYC` rising clock edges without service, whichever comes first. `long_mode` then reads 0.
- R4: In short mode, `wd_fault_n` goes to 0 on the `SHORT_CYC`-th rising clock edge after the last reload, if no service has come in the meantime.
- R5: A `kick_in` held steadily high, or held steadily low, never prevents a fault. No input level disables the timer.
- R6: Once `wd_fault_n` is 0, it stays 0 until a service edge or a reset event.
- R7: A change on `kick_in` made between clock edges takes effect on the third rising clock edge after it. The path is two synchronizer flops followed by edge detection.
- R8: Asserting `sys_rst` during a fault returns `wd_fault_n` to 1 at once. After release, the timer runs a full long window again.
- R9: A service edge that lands in the final cycle of a window wins over the expiry. It reloads the counter and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Reset event, active high, asynchronous assert |
| kick_in | input | 1 | Asynchronous service line from the processor |
| wd_fault_n | output | 1 | Watchdog fault, active low, registered |
| long_mode | output | 1 | 1 while the boot (long) window is active |

## Verification
The assertions assume that `sys_rst` is released synchronously to `clk`. They also assume that `kick_in` is low while reset is held, since the synchronizer flops clear to 0 and a high line at release would look like a service edge. The stimulus changes `kick_in` only on falling clock edges and drives it low before every reset. Each input therefore passes cleanly through the synchronizer, and every edge is detected exactly three rising edges later. The assertions also rely on `LONG_CYC` being greater than `SHORT_CYC` and `SHORT_CYC` being at least 2, so the counter never reaches zero. The bench keeps to both.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_LONG  = 2'd0,
        ST_SHORT = 2'd1,
        ST_FAULT = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync (
    input  logic clk,
    input  logic sys_rst,
    input  logic kick_in,
    output logic kick_edge
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or posedge sys_rst) begin
        if (sys_rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= kick_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // either polarity of transition is a service
    assign kick_edge = sync_q ^ prev_q;
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
    parameter int unsigned CNT_W = 8,
    parameter longint unsigned RST_VAL = 64'd12
) (
    input  logic             clk,
    input  logic             sys_rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             at_one
);
    always_ff @(posedge clk or posedge sys_rst) begin
        if (sys_rst) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign at_one = (cnt == CNT_W'(1));
endmodule

// File: rtl/wdog_mode_fsm.sv
module wdog_mode_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter longint unsigned SHORT_CYC = 64'd5
) (
    input  logic             clk,
    input  logic             sys_rst,
    input  logic             kick_edge,
    input  logic             cnt_at_one,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic             cnt_dec,
    output logic             wd_fault_n,
    output logic             long_mode
);
    wd_state_e st_q;
    wd_state_e st_nxt;

    // state register
    always_ff @(posedge clk or posedge sys_rst) begin
        if (sys_rst) st_q <= ST_LONG;   // T_RESET
        else         st_q <= st_nxt;
    end

    // next state and counter control
    always_comb begin
        st_nxt       = st_q;
        cnt_load     = 1'b0;
        cnt_dec      = 1'b0;
        cnt_load_val = CNT_W'(SHORT_CYC);
        unique case (st_q)
            ST_LONG: begin
                if (kick_edge) begin          // T_BOOT_KICK
                    st_nxt   = ST_SHORT;
                    cnt_load = 1'b1;
                end else if (cnt_at_one) begin // T_BOOT_EXPIRE
                    st_nxt   = ST_SHORT;
                    cnt_load = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_SHORT: begin
                if (kick_edge) begin          // T_SERVICE
                    cnt_load = 1'b1;
                end else if (cnt_at_one) begin // T_MISS
                    st_nxt = ST_FAULT;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_FAULT: begin
                if (kick_edge) begin          // T_RECOVER
                    st_nxt   = ST_SHORT;
                    cnt_load = 1'b1;
                end
            end
            default: st_nxt = ST_LONG;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or posedge sys_rst) begin
        if (sys_rst) begin
            wd_fault_n <= 1'b1;
            long_mode  <= 1'b1;
        end else begin
            wd_fault_n <= (st_nxt != ST_FAULT);
            long_mode  <= (st_nxt == ST_LONG);
        end
    end

    assert_edge_exits_long_R3: assert property (@(posedge clk) disable iff (sys_rst)
        (st_q == ST_LONG && kick_edge) |=> !long_mode);

    assert_fault_after_last_count_R4: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(wd_fault_n) |-> $past(cnt_at_one));

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (sys_rst)
        (!wd_fault_n && !kick_edge) |=> !wd_fault_n);

    assert_cnt_never_zero_R2: assert property (@(posedge clk) disable iff (sys_rst)
        cnt != '0);
endmodule

// File: rtl/wdog_dual_period.sv
module wdog_dual_period #(
    parameter longint unsigned LONG_CYC  = 64'd3_500_000_000,
    parameter longint unsigned SHORT_CYC = 64'd112_000_000
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic kick_in,
    output logic wd_fault_n,
    output logic long_mode
);
    localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);

    generate
        if (!(LONG_CYC > SHORT_CYC && SHORT_CYC >= 2)) begin : g_bad_cfg
            $error("wdog_dual_period: need LONG_CYC > SHORT_CYC >= 2");
        end
    endgenerate

    logic             kick_edge;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_at_one;
    logic [CNT_W-1:0] cnt_load_val;
    logic [CNT_W-1:0] cnt;

    wdog_kick_sync u_sync (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .kick_in   (kick_in),
        .kick_edge (kick_edge)
    );

    wdog_down_counter #(
        .CNT_W   (CNT_W),
        .RST_VAL (LONG_CYC)
    ) u_cnt (
        .clk      (clk),
        .sys_rst  (sys_rst),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .at_one   (cnt_at_one)
    );

    wdog_mode_fsm #(
        .CNT_W     (CNT_W),
        .SHORT_CYC (SHORT_CYC)
    ) u_fsm (
        .clk          (clk),
        .sys_rst      (sys_rst),
        .kick_edge    (kick_edge),
        .cnt_at_one   (cnt_at_one),
        .cnt          (cnt),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .cnt_dec      (cnt_dec),
        .wd_fault_n   (wd_fault_n),
        .long_mode    (long_mode)
    );

    assert_edge_clears_fault_R1: assert property (@(posedge clk) disable iff (sys_rst)
        kick_edge |=> (wd_fault_n && !long_mode));
endmodule

// File: tb/wdog_dual_period_tb_top.sv
module wdog_dual_period_tb_top;
    localparam longint unsigned LONG_CYC  = 64'd12;
    localparam longint unsigned SHORT_CYC = 64'd5;
    localparam int NVEC = 15;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic kick_in = 1'b0;
    logic wd_fault_n;
    logic long_mode;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wdog_dual_period #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) dut_i (
        .clk        (clk),
        .sys_rst    (sys_rst),
        .kick_in    (kick_in),
        .wd_fault_n (wd_fault_n),
        .long_mode  (long_mode)
    );

    // {kick level, rising edges to wait, expected fault_n, expected long_mode}
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 8'd11, 1'b1, 1'b1},  // R2 long window still open
        {1'b0, 8'd1,  1'b1, 1'b0},  // R3 expiry after 12 edges
        {1'b0, 8'd4,  1'b1, 1'b0},  // R4 short window, one left
        {1'b0, 8'd1,  1'b0, 1'b0},  // R5 held low -> fault
        {1'b0, 8'd3,  1'b0, 1'b0},  // R6 fault persists
        {1'b1, 8'd1,  1'b0, 1'b0},  // R7 first sync flop
        {1'b1, 8'd1,  1'b0, 1'b0},  // R7 second sync flop
        {1'b1, 8'd1,  1'b1, 1'b0},  // R1 rising edge recovers
        {1'b1, 8'd4,  1'b1, 1'b0},  // R4 count down
        {1'b1, 8'd1,  1'b0, 1'b0},  // R5 held high -> fault
        {1'b0, 8'd3,  1'b1, 1'b0},  // R1 falling edge recovers
        {1'b0, 8'd2,  1'b1, 1'b0},  // R4 partial window
        {1'b1, 8'd3,  1'b1, 1'b0},  // R9 edge on last cycle wins
        {1'b1, 8'd4,  1'b1, 1'b0},  // R4 reloaded window
        {1'b1, 8'd1,  1'b0, 1'b0}   // R6 fault after reload
    };
    string tags [NVEC] = '{"R2","R3","R4","R5","R6","R7","R7","R1",
                           "R4","R5","R1","R4","R9","R4","R6"};

    task automatic check(input string tag, input logic exp_f, input logic exp_l);
        n_checks++;
        if (wd_fault_n !== exp_f || long_mode !== exp_l) begin
            n_fail++;
            $display("FAIL %s: fault_n=%b long_mode=%b expected fault_n=%b long_mode=%b",
                     tag, wd_fault_n, long_mode, exp_f, exp_l);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2", 1'b1, 1'b1);            // reset state
        sys_rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            kick_in = VEC[i][10];
            repeat (int'(VEC[i][9:2])) @(negedge clk);
            check(tags[i], VEC[i][1], VEC[i][0]);
        end

        // R8: reset while faulted clears at once
        kick_in = 1'b0;
        sys_rst = 1'b1;
        #1;
        check("R8", 1'b1, 1'b1);
        @(negedge clk);
        sys_rst = 1'b0;

        // R3: early exit from long mode on first edge
        repeat (3) @(negedge clk);
        kick_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R7", 1'b1, 1'b1);
        @(negedge clk);
        check("R3", 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check("R4", 1'b1, 1'b0);
        @(negedge clk);
        check("R4", 1'b0, 1'b0);

        // R8: after release a full long window runs again
        kick_in = 1'b0;
        sys_rst = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0;
        repeat (11) @(negedge clk);
        check("R8", 1'b1, 1'b1);
        @(negedge clk);
        check("R8", 1'b1, 1'b0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end
endmodule